// File: doc/BRIEF.md
# Indirect Register Access Bridge for Byte-Wide Peripherals

The bridge gives a host access to the 8-bit registers of two slow byte-wide peripheral devices through a single 32-bit command/status word. The host never touches the peripheral bus itself. Instead it posts a command word. The bridge then runs exactly one timed cycle on a local guest bus and raises a pending flag until that cycle has finished.

Each peripheral register access needs two posted commands. The first is an address phase: a write to the guest's address register that carries the target offset. The second is a data phase: a read or write of the guest's data register. The host polls the pending flag between the two commands.

The offset byte goes to the peripheral unchanged. A second channel inside one peripheral is reached by adding 0x40 to the offset. Repeated accesses to a FIFO offset each need their own address phase. When a read finishes, the fetched byte is returned in the low byte of the status word.

Top module: `regport_bridge`

## Requirements
- R1: After reset the status word reads 0, pending and overrun are clear, and every chip select, strobe and the data output enable are low.
- R2: The command/status word sits at byte offset 0x200 of the host window. A read at any other offset returns 0. A write at any other offset starts no guest cycle.
- R3: Command word fields are as follows. Bit 23 selects write (1) or read (0). Bit 20 selects guest 1 or guest 0, which asserts `gst_cs_o[1]` or `gst_cs_o[0]`. Bit 16 selects the data register (`gst_ad_o`=1) or the address register (`gst_ad_o`=0). Bits 7:0 carry the byte, which is driven onto `gst_dout_o` unchanged.
- R4: Status bit 25 (pending) reads 1 from the first cycle after a command is accepted. It stays 1 for exactly CYC_CLKS+1 cycles and then reads 0.
- R5: During a guest cycle, one chip select, `gst_ad_o`, and one of `gst_rd_o` or `gst_wr_o` are held for exactly CYC_CLKS clocks. At most one chip select is ever high, and read and write strobes are never high together.
- R6: For a write, `gst_doe_o` and the byte on `gst_dout_o` are held for the whole strobe and for one clock after it ends. For a read, `gst_doe_o` stays low.
- R7: A read samples `gst_din_i` on the last strobe clock. The byte appears in status bits 7:0 by the time pending reads 0.
- R8: The read byte in bits 7:0 keeps its value until the next read completes. Write commands leave it unchanged.
- R9: A command written while pending is 1 is ignored: it causes no guest cycle and no register change. It also sets the sticky overrun flag, status bit 31.
- R10: A write to offset 0x200 with bit 31 set clears overrun and starts no guest cycle.
- R11: An address phase followed by a data phase reaches every offset 0..255 of both guests. This includes offsets with 0x40 added, and repeated accesses to one FIFO offset that each have their own address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_sel_i | input | 1 | Host access strobe for the register window |
| host_we_i | input | 1 | Host write (1) or read (0) |
| host_addr_i | input | HADDR_W | Byte offset within the host window |
| host_wdata_i | input | 32 | Host write data (command word) |
| host_rdata_o | output | 32 | Status word when the command offset is selected, else 0 |
| gst_cs_o | output | 2 | Chip selects, one per guest, active high |
| gst_ad_o | output | 1 | Register select: 0 address register, 1 data register |
| gst_rd_o | output | 1 | Read strobe |
| gst_wr_o | output | 1 | Write strobe |
| gst_doe_o | output | 1 | Output enable for gst_dout_o |
| gst_dout_o | output | 8 | Byte driven to the guest |
| gst_din_i | input | 8 | Byte returned by the guest |

## Verification
A behavioural model of two peripherals, each with an address register and 256 data bytes, sits on the guest bus. A full read sweep over both guests and all 256 offsets tells apart mistakes in guest selection, offset pass-through and read-byte capture, because the expected contents are arithmetic in both guest and offset. A sparse write sweep, including +0x40 channel offsets and repeated FIFO-offset writes, is then read back and shows whether the data phase lands on the register that the preceding address phase named. Single commands are traced clock by clock to measure strobe length, pending length and write-data hold. Commands posted back to back, and commands at a wrong offset, separate an accepted command from an ignored one through the guest model's strobe count and its address register.

// File: rtl/rpb_pkg.sv
package rpb_pkg;
  localparam int WORD_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int N_GST    = 2;
  localparam int BIT_OVR  = 31;
  localparam int BIT_PEND = 25;
  localparam int BIT_WR   = 23;
  localparam int BIT_GID  = 20;
  localparam int BIT_GREG = 16;

  typedef struct packed {
    logic              wr;
    logic              gid;
    logic              greg;
    logic [BYTE_W-1:0] data;
  } gcmd_t;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_STROBE = 2'd1,
    SQ_HOLD   = 2'd2
  } sq_state_e;
endpackage

// File: rtl/rpb_host_port.sv
module rpb_host_port
  import rpb_pkg::*;
#(
  parameter int              HADDR_W = 12,
  parameter logic [HADDR_W-1:0] CMD_OFF = 12'h200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [HADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              pend_i,
  input  logic [BYTE_W-1:0] rbyte_i,
  output logic              start_o,
  output gcmd_t             cmd_o,
  output logic [WORD_W-1:0] status_o,
  output logic [WORD_W-1:0] rdata_o
);
  logic hit, wr_hit, clr_req, cmd_req, ovr_q;
  logic unused_bits;

  assign hit     = sel_i && (addr_i == CMD_OFF);
  assign wr_hit  = hit && we_i;
  assign clr_req = wr_hit && wdata_i[BIT_OVR];
  assign cmd_req = wr_hit && !wdata_i[BIT_OVR];
  assign start_o = cmd_req && !pend_i;

  assign cmd_o.wr   = wdata_i[BIT_WR];
  assign cmd_o.gid  = wdata_i[BIT_GID];
  assign cmd_o.greg = wdata_i[BIT_GREG];
  assign cmd_o.data = wdata_i[BYTE_W-1:0];

  assign unused_bits = ^{wdata_i[30:24], wdata_i[22:21], wdata_i[19:17], wdata_i[15:8]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ovr_q <= 1'b0;
    else if (clr_req)            ovr_q <= 1'b0;
    else if (cmd_req && pend_i)  ovr_q <= 1'b1;
  end

  always_comb begin
    status_o                = '0;
    status_o[BIT_OVR]       = ovr_q;
    status_o[BIT_PEND]      = pend_i;
    status_o[BYTE_W-1:0]    = rbyte_i;
  end

  assign rdata_o = hit ? status_o : '0;
endmodule

// File: rtl/rpb_guest_seq.sv
module rpb_guest_seq
  import rpb_pkg::*;
#(
  parameter int CYC_CLKS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  gcmd_t             cmd_i,
  input  logic [BYTE_W-1:0] din_i,
  output logic              pend_o,
  output logic [BYTE_W-1:0] rbyte_o,
  output logic [N_GST-1:0]  cs_o,
  output logic              ad_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              doe_o,
  output logic [BYTE_W-1:0] dout_o
);
  localparam int CNT_W = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYC_CLKS - 1);

  sq_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  gcmd_t             cmd_q;
  logic [BYTE_W-1:0] rbyte_q;
  logic              strobe, hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      cmd_q   <= '0;
      rbyte_q <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (start_i) begin
          cmd_q   <= cmd_i;
          cnt_q   <= '0;
          state_q <= SQ_STROBE;
        end
        SQ_STROBE: if (cnt_q == CNT_LAST) begin
          state_q <= SQ_HOLD;
          if (!cmd_q.wr) rbyte_q <= din_i;  // sample on last strobe clock
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
        SQ_HOLD: state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign strobe  = (state_q == SQ_STROBE);
  assign hold    = (state_q == SQ_HOLD);
  assign pend_o  = (state_q != SQ_IDLE);
  assign rbyte_o = rbyte_q;

  for (genvar g = 0; g < N_GST; g++) begin : g_cs
    assign cs_o[g] = strobe && (cmd_q.gid == 1'(g));
  end

  assign ad_o   = strobe && cmd_q.greg;
  assign rd_o   = strobe && !cmd_q.wr;
  assign wr_o   = strobe && cmd_q.wr;
  // write data stays one clock past the strobe
  assign doe_o  = (strobe || hold) && cmd_q.wr;
  assign dout_o = doe_o ? cmd_q.data : '0;
endmodule

// File: rtl/regport_bridge.sv
module regport_bridge
  import rpb_pkg::*;
#(
  parameter int                 HADDR_W  = 12,
  parameter logic [HADDR_W-1:0] CMD_OFF  = 12'h200,
  parameter int                 CYC_CLKS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_sel_i,
  input  logic               host_we_i,
  input  logic [HADDR_W-1:0] host_addr_i,
  input  logic [31:0]        host_wdata_i,
  output logic [31:0]        host_rdata_o,
  output logic [1:0]         gst_cs_o,
  output logic               gst_ad_o,
  output logic               gst_rd_o,
  output logic               gst_wr_o,
  output logic               gst_doe_o,
  output logic [7:0]         gst_dout_o,
  input  logic [7:0]         gst_din_i
);
  logic              start_w, pend_w;
  gcmd_t             cmd_w;
  logic [BYTE_W-1:0] rbyte_w;
  logic [WORD_W-1:0] status_w;

  rpb_host_port #(.HADDR_W(HADDR_W), .CMD_OFF(CMD_OFF)) u_host (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (host_sel_i),
    .we_i     (host_we_i),
    .addr_i   (host_addr_i),
    .wdata_i  (host_wdata_i),
    .pend_i   (pend_w),
    .rbyte_i  (rbyte_w),
    .start_o  (start_w),
    .cmd_o    (cmd_w),
    .status_o (status_w),
    .rdata_o  (host_rdata_o)
  );

  rpb_guest_seq #(.CYC_CLKS(CYC_CLKS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_w),
    .cmd_i   (cmd_w),
    .din_i   (gst_din_i),
    .pend_o  (pend_w),
    .rbyte_o (rbyte_w),
    .cs_o    (gst_cs_o),
    .ad_o    (gst_ad_o),
    .rd_o    (gst_rd_o),
    .wr_o    (gst_wr_o),
    .doe_o   (gst_doe_o),
    .dout_o  (gst_dout_o)
  );
endmodule

// File: rtl/rpb_checker.sv
module rpb_checker #(
  parameter int                 HADDR_W  = 12,
  parameter logic [HADDR_W-1:0] CMD_OFF  = 12'h200,
  parameter int                 CYC_CLKS = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               host_sel_i,
  input logic               host_we_i,
  input logic [HADDR_W-1:0] host_addr_i,
  input logic [31:0]        host_wdata_i,
  input logic [31:0]        status_w,
  input logic [1:0]         gst_cs_o,
  input logic               gst_rd_o,
  input logic               gst_wr_o,
  input logic               gst_doe_o,
  input logic [7:0]         gst_dout_o
);
  logic        strb, strb_q;
  logic [15:0] len_q;
  logic        cmd_wr;

  assign strb   = gst_rd_o || gst_wr_o;
  assign cmd_wr = host_sel_i && host_we_i && (host_addr_i == CMD_OFF) && !host_wdata_i[31];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q <= 1'b0;
      len_q  <= '0;
    end else begin
      strb_q <= strb;
      len_q  <= strb ? len_q + 16'd1 : 16'd0;
    end
  end

  // R5
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(gst_cs_o));
  // R5
  strb_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) strb |-> (!(gst_rd_o && gst_wr_o) && (gst_cs_o != 2'b00)));
  // R5
  strb_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) (!strb && strb_q) |-> (len_q == 16'(CYC_CLKS)));
  // R4
  strb_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) strb |-> status_w[25]);
  // R6
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(gst_wr_o) |-> (gst_doe_o && $stable(gst_dout_o)));
  // R6
  rd_noe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) gst_rd_o |-> !gst_doe_o);
  // R8
  rbyte_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) gst_wr_o |-> $stable(status_w[7:0]));
  // R9
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) (cmd_wr && status_w[25]) |=> status_w[31]);
endmodule

bind regport_bridge rpb_checker #(
  .HADDR_W(HADDR_W), .CMD_OFF(CMD_OFF), .CYC_CLKS(CYC_CLKS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_sel_i   (host_sel_i),
  .host_we_i    (host_we_i),
  .host_addr_i  (host_addr_i),
  .host_wdata_i (host_wdata_i),
  .status_w     (status_w),
  .gst_cs_o     (gst_cs_o),
  .gst_rd_o     (gst_rd_o),
  .gst_wr_o     (gst_wr_o),
  .gst_doe_o    (gst_doe_o),
  .gst_dout_o   (gst_dout_o)
);

// File: tb/sim_regport_bridge.sv
`timescale 1ns/1ps
module sim_regport_bridge;
  localparam int CYC = 4;
  localparam logic [11:0] CMD = 12'h200;
  localparam logic [31:0] F_WR = 32'h0080_0000;
  localparam logic [31:0] F_G1 = 32'h0010_0000;
  localparam logic [31:0] F_DR = 32'h0001_0000;
  localparam logic [31:0] F_OV = 32'h8000_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [11:0] addr = CMD;
  logic [31:0] wdata = '0, rdata;
  logic [1:0]  cs;
  logic        ad, rd, wr, doe;
  logic [7:0]  dout, din;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem [2][256];
  logic [7:0] areg [2];
  logic [7:0] shadow [2][256];
  logic       strb_q;
  int         strobes;

  always #2.5 clk = ~clk;

  regport_bridge #(.HADDR_W(12), .CMD_OFF(12'h200), .CYC_CLKS(CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .host_sel_i(sel), .host_we_i(we), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .gst_cs_o(cs), .gst_ad_o(ad),
    .gst_rd_o(rd), .gst_wr_o(wr), .gst_doe_o(doe), .gst_dout_o(dout), .gst_din_i(din)
  );

  function automatic logic [7:0] finit(input int g, input int a);
    return 8'((a * 3) + (g != 0 ? 8'h5A : 8'h11));
  endfunction

  // peripheral model: address register plus 256 bytes per guest
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 2; g++) begin
        areg[g] <= 8'h00;
        for (int a = 0; a < 256; a++) mem[g][a] <= finit(g, a);
      end
      strb_q  <= 1'b0;
      strobes <= 0;
    end else begin
      strb_q <= rd || wr;
      if ((rd || wr) && !strb_q) strobes <= strobes + 1;
      for (int g = 0; g < 2; g++)
        if (cs[g] && wr) begin
          if (!ad) areg[g] <= dout;
          else     mem[g][areg[g]] <= dout;
        end
    end
  end

  assign din = (cs[0] && rd) ? (ad ? mem[0][areg[0]] : areg[0]) :
               (cs[1] && rd) ? (ad ? mem[1][areg[1]] : areg[1]) : 8'h00;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [11:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; addr = CMD; wdata = '0;
  endtask

  task automatic hrd(input logic [11:0] a, output logic [31:0] v);
    sel = 1'b1; we = 1'b0; addr = a;
    #0.5;
    v = rdata;
    sel = 1'b0; addr = CMD;
  endtask

  task automatic poll(output int n);
    logic [31:0] v;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      hrd(CMD, v);
      if (!v[25]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic acc(input int g, input logic [7:0] off, input bit w, input logic [7:0] d,
                     output logic [7:0] rb);
    int n;
    logic [31:0] v;
    hwr(CMD, F_WR | (g != 0 ? F_G1 : 32'h0) | {24'h0, off});
    poll(n);
    hwr(CMD, (w ? F_WR : 32'h0) | (g != 0 ? F_G1 : 32'h0) | F_DR | {24'h0, d});
    poll(n);
    hrd(CMD, v);
    rb = v[7:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  rb, last_rd;
    int          n, pc, wc, s0;
    bit          hold_ok, seen_hold, rd_oe, flags_ok;

    for (int g = 0; g < 2; g++)
      for (int a = 0; a < 256; a++) shadow[g][a] = finit(g, a);

    repeat (3) @(negedge clk);
    hrd(CMD, v);
    chk(v == 32'h0, "R1 status after reset", v, 32'h0);
    chk({cs, rd, wr, doe} == 5'b0, "R1 guest pins in reset", {27'h0, cs, rd, wr, doe}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    hrd(CMD, v);
    chk(v == 32'h0, "R1 status after release", v, 32'h0);

    // R2: wrong offset
    s0 = strobes;
    hwr(12'h204, F_WR | 32'h12);
    hrd(CMD, v);
    chk(v[25] == 1'b0, "R2 write elsewhere starts nothing", v, 32'h0);
    repeat (CYC + 2) @(negedge clk);
    chk(strobes == s0, "R2 no guest cycle", strobes, s0);
    hrd(12'h204, v);
    chk(v == 32'h0, "R2 read elsewhere is zero", v, 32'h0);

    // R3 R4 R5 R6: address write to guest 1, offset 0x5F, traced per clock
    hwr(CMD, F_WR | F_G1 | 32'h5F);
    pc = 0; wc = 0; hold_ok = 1'b0; seen_hold = 1'b0; flags_ok = 1'b1;
    for (int i = 0; i < 50; i++) begin
      hrd(CMD, v);
      if (!v[25]) break;
      pc++;
      if (wr) begin
        wc++;
        if (!(cs == 2'b10 && !ad && !rd && doe && dout == 8'h5F)) flags_ok = 1'b0;
      end else if (!seen_hold) begin
        seen_hold = 1'b1;
        hold_ok = doe && (dout == 8'h5F) && (cs == 2'b00);
      end
      @(negedge clk);
    end
    chk(flags_ok, "R3 guest1 address-phase pins", {24'h0, dout}, 32'h5F);
    chk(pc == CYC + 1, "R4 pending length", pc, CYC + 1);
    chk(wc == CYC, "R5 write strobe length", wc, CYC);
    chk(hold_ok, "R6 write data hold after strobe", {31'h0, hold_ok}, 32'h1);
    chk(areg[1] == 8'h5F, "R3 offset passed unchanged", areg[1], 32'h5F);

    // R7 R6: data read from guest 1
    hwr(CMD, F_G1 | F_DR);
    wc = 0; rd_oe = 1'b0; flags_ok = 1'b1;
    for (int i = 0; i < 50; i++) begin
      hrd(CMD, v);
      if (!v[25]) break;
      if (rd) begin
        wc++;
        if (!(cs == 2'b10 && ad)) flags_ok = 1'b0;
      end
      if (doe) rd_oe = 1'b1;
      @(negedge clk);
    end
    chk(wc == CYC, "R5 read strobe length", wc, CYC);
    chk(flags_ok, "R3 data-phase select on guest1", {30'h0, cs}, 32'h2);
    chk(!rd_oe, "R6 no output enable on read", {31'h0, rd_oe}, 32'h0);
    hrd(CMD, v);
    chk(v[7:0] == shadow[1][8'h5F] && !v[25], "R7 read byte in status", v, {24'h0, shadow[1][8'h5F]});
    last_rd = v[7:0];

    // R8: write leaves read byte
    acc(0, 8'h1E, 1'b1, 8'hC3, rb);
    shadow[0][8'h1E] = 8'hC3;
    chk(rb == last_rd, "R8 write keeps read byte", rb, last_rd);

    // R9: command while pending
    s0 = strobes;
    hwr(CMD, F_WR | 32'h1E);
    hwr(CMD, F_WR | 32'h77);
    poll(n);
    hrd(CMD, v);
    chk(v[31], "R9 overrun set", v, 32'h8000_0000);
    chk(strobes == s0 + 1, "R9 second command dropped", strobes, s0 + 1);
    chk(areg[0] == 8'h1E, "R9 address unchanged by dropped command", areg[0], 32'h1E);

    // R10: clear overrun
    s0 = strobes;
    hwr(CMD, F_OV);
    hrd(CMD, v);
    chk(!v[31] && !v[25], "R10 overrun cleared, no cycle", v, {24'h0, last_rd});
    repeat (CYC + 2) @(negedge clk);
    chk(strobes == s0, "R10 no guest cycle", strobes, s0);

    // R11: sparse writes incl. +0x40 channel and FIFO repeats
    for (int g = 0; g < 2; g++)
      for (int a = 5; a < 256; a += 23) begin
        acc(g, 8'(a), 1'b1, 8'(~a + g), rb);
        shadow[g][a] = 8'(~a + g);
      end
    acc(1, 8'h50, 1'b1, 8'hE1, rb); shadow[1][8'h50] = 8'hE1;
    acc(1, 8'h10, 1'b1, 8'h2B, rb); shadow[1][8'h10] = 8'h2B;
    for (int k = 0; k < 3; k++) begin
      acc(1, 8'h1F, 1'b1, 8'(8'h90 + k), rb);
      shadow[1][8'h1F] = 8'(8'h90 + k);
    end

    // R11: full read sweep
    for (int g = 0; g < 2; g++)
      for (int a = 0; a < 256; a++) begin
        acc(g, 8'(a), 1'b0, 8'h00, rb);
        chk(rb == shadow[g][a], $sformatf("R11 readback g%0d off %0h", g, a), rb, shadow[g][a]);
      end
    last_rd = rb;

    acc(0, 8'h40, 1'b1, 8'h0F, rb);
    chk(rb == last_rd, "R8 read byte kept after sweep write", rb, last_rd);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule